// File: doc/BRIEF.md
# Stack-Addressed Register File

This block holds eight 64-bit registers. Hardware manages them as a stack. Nothing moves between registers on a push or a pop. A 3-bit top pointer moves instead, and every operand index counts from that pointer. Relative index 0 is the top. Index 1 is the register just beneath it, and so on, wrapping modulo eight. Each register carries a tag that says whether it holds a value.

The datapath drives one command per cycle. The commands are:
- initialise
- push a new value
- store the top without popping it
- store the top and pop it
- operate-and-pop: write a value supplied from outside to relative entry i, then pop the top

A separate combinational read port returns any relative entry together with its tag. The block does no arithmetic; any combined result arrives as plain data.

A push onto a register that still holds a value sets a sticky overflow flag and changes nothing. Touching a register that holds no value also changes nothing, and sets a sticky underflow flag. That covers a store, a pop, an operate-and-pop target, or a read with its enable set. Both flags clear only on initialise or reset.

Top module: `stk_regfile`

## Requirements
- R1: After reset, and in the cycle after an initialise command (cmd_op 1), the top pointer is 0, all eight tags are empty and both flags are clear.
- R2: rd_data and rd_valid show the data and tag of physical register (top + rd_idx) mod 8 in the same cycle, without a clock edge.
- R3: A push (cmd_op 2) onto an empty register at (top - 1) mod 8 writes cmd_data there, tags it valid and moves the top pointer to it. If that register is already valid, ovf_flag is set and the pointer, tags and data stay unchanged.
- R4: A store (cmd_op 3) with a valid top raises st_valid for one cycle, one cycle after the command, with st_data equal to the top value. The pointer and tags stay unchanged.
- R5: A store-and-pop (cmd_op 4) with a valid top behaves as R4. In addition it tags the old top empty and increments the top pointer modulo 8.
- R6: An operate-and-pop (cmd_op 5) with cmd_idx naming a valid entry, relative to the top before the command, and with a valid top writes cmd_data to that entry and then pops the top. With cmd_idx 0 the written value is discarded by the pop.
- R7: A store or store-and-pop with an empty top, an operate-and-pop with an empty top or an empty target, or a read with rd_en high at an empty entry sets unf_flag. The failed command leaves the pointer, tags and data unchanged.
- R8: ovf_flag and unf_flag stay set until an initialise command or reset.
- R9: With cmd_valid low, or with cmd_op 0, 6 or 7, the pointer, tags, data and flags are unchanged and st_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 idle, 1 init, 2 push, 3 store, 4 store-pop, 5 operate-pop) |
| cmd_idx | input | 3 | Relative target entry for operate-pop |
| cmd_data | input | 64 | Push value or operate-pop result |
| rd_en | input | 1 | Marks the read as a use, so that an empty entry raises underflow |
| rd_idx | input | 3 | Relative entry for the read port |
| rd_data | output | 64 | Data of the addressed relative entry |
| rd_valid | output | 1 | Tag of the addressed relative entry |
| st_valid | output | 1 | Store result valid |
| st_data | output | 64 | Stored top value |
| top_ptr | output | 3 | Physical index of the stack top |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The checker watches the following on every cycle:
- After an initialise, the block is in its empty state.
- The overflow flag only rises on a push, and the pointer holds still when it does.
- The flags are sticky.
- A plain store and an idle cycle leave the pointer and tags alone.
- The pointer moves by at most one on an operate-and-pop.
- st_valid only follows a store command.

Only the bench's scenarios can show that the right values sit in the right relative slots after pushes and pops wrap the pointer. The same holds for st_data carrying the top value and for operate-and-pop hitting the chosen entry. They also show that a rejected push or pop leaves every entry intact. The bench confirms these by sweeping the read port over all eight relative entries after each command.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_INIT     = 3'd1,
    OP_PUSH     = 3'd2,
    OP_STORE    = 3'd3,
    OP_STOREPOP = 3'd4,
    OP_OPPOP    = 3'd5
  } stk_op_e;

endpackage

// File: rtl/stk_ptr.sv
// Top-of-stack pointer: wraps modulo DEPTH (power of two).
module stk_ptr #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] ptr_q
);

  logic [IDX_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_d = ptr_q;
    if (init)      ptr_d = '0;
    else if (push) ptr_d = ptr_q - 1'b1;
    else if (pop)  ptr_d = ptr_q + 1'b1;
  end

  assign ptr_en = init | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/stk_tags.sv
// One valid tag per physical register; clear has priority over set.
module stk_tags #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_addr,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_addr,
  output logic [DEPTH-1:0] tags_q
);

  logic [DEPTH-1:0] tags_d;
  logic             tags_en;

  always_comb begin
    tags_d = tags_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (set_en && set_addr == IDX_W'(i)) tags_d[i] = 1'b1;
      if (clr_en && clr_addr == IDX_W'(i)) tags_d[i] = 1'b0;
    end
    if (init) tags_d = '0;
  end

  assign tags_en = init | set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tags_q <= '0;
    else if (tags_en) tags_q <= tags_d;
  end

endmodule

// File: rtl/stk_bank.sv
// Data registers: one write port, two combinational read ports.
module stk_bank #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [IDX_W-1:0]  rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              ent_en;
    logic [DATA_W-1:0] ent_q;

    assign ent_en = wr_en && (wr_addr == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= wr_data;
    end

    assign ent[g] = ent_q;
  end

  assign rd_data_a = ent[rd_addr_a];
  assign rd_data_b = ent[rd_addr_b];

endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter  int unsigned DATA_W = 64,
  parameter  int unsigned DEPTH  = 8,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic [IDX_W-1:0]  top_ptr,
  output logic              ovf_flag,
  output logic              unf_flag
);
  import stk_pkg::*;

  logic [IDX_W-1:0]  ptr_q;
  logic [DEPTH-1:0]  tags_q;
  logic [IDX_W-1:0]  push_addr, tgt_addr, rd_addr;
  logic              is_init, is_push, is_store, is_stpop, is_oppop;
  logic              top_ok, push_ok, ovf_evt, st_ok, oppop_ok, pop, unf_evt;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [DATA_W-1:0] top_data;
  logic              ovf_d, unf_d, ovf_q, unf_q, flag_en;
  logic              st_valid_q;
  logic [DATA_W-1:0] st_data_q;

  // Command decode
  always_comb begin
    is_init  = cmd_valid && (cmd_op == OP_INIT);
    is_push  = cmd_valid && (cmd_op == OP_PUSH);
    is_store = cmd_valid && (cmd_op == OP_STORE);
    is_stpop = cmd_valid && (cmd_op == OP_STOREPOP);
    is_oppop = cmd_valid && (cmd_op == OP_OPPOP);
  end

  // Relative-to-physical mapping
  assign push_addr = ptr_q - 1'b1;
  assign tgt_addr  = ptr_q + cmd_idx;
  assign rd_addr   = ptr_q + rd_idx;

  always_comb begin
    top_ok   = tags_q[ptr_q];
    push_ok  = is_push && !tags_q[push_addr];
    ovf_evt  = is_push && tags_q[push_addr];
    st_ok    = (is_store || is_stpop) && top_ok;
    oppop_ok = is_oppop && top_ok && tags_q[tgt_addr];
    pop      = (is_stpop && top_ok) || oppop_ok;
    unf_evt  = ((is_store || is_stpop) && !top_ok)
             || (is_oppop && !oppop_ok)
             || (rd_en && !tags_q[rd_addr]);
    wr_en    = push_ok || oppop_ok;
    wr_addr  = push_ok ? push_addr : tgt_addr;
  end

  stk_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (is_init),
    .push  (push_ok),
    .pop   (pop),
    .ptr_q (ptr_q)
  );

  stk_tags #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (is_init),
    .set_en   (push_ok),
    .set_addr (push_addr),
    .clr_en   (pop),
    .clr_addr (ptr_q),
    .tags_q   (tags_q)
  );

  stk_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (cmd_data),
    .rd_addr_a (rd_addr),
    .rd_data_a (rd_data),
    .rd_addr_b (ptr_q),
    .rd_data_b (top_data)
  );

  // Sticky flags
  always_comb begin
    ovf_d   = is_init ? 1'b0 : (ovf_q | ovf_evt);
    unf_d   = is_init ? 1'b0 : (unf_q | unf_evt);
    flag_en = is_init | ovf_evt | unf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (flag_en) begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  // Store output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_valid_q <= 1'b0;
    else        st_valid_q <= st_ok;
  end

  always_ff @(posedge clk) begin
    if (st_ok) st_data_q <= top_data;
  end

  assign rd_valid = tags_q[rd_addr];
  assign st_valid = st_valid_q;
  assign st_data  = st_data_q;
  assign top_ptr  = ptr_q;
  assign ovf_flag = ovf_q;
  assign unf_flag = unf_q;

endmodule

// File: rtl/stk_regfile_chk.sv
module stk_regfile_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             rd_en,
  input logic [IDX_W-1:0] top_ptr,
  input logic [DEPTH-1:0] tags_q,
  input logic             ovf_flag,
  input logic             unf_flag,
  input logic             st_valid
);

  assert_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=>
      (top_ptr == '0 && tags_q == '0 && !ovf_flag && !unf_flag));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> ($past(cmd_valid && cmd_op == 3'd2) && $stable(top_ptr)));

  assert_store_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3) |=> ($stable(top_ptr) && $stable(tags_q)));

  assert_st_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4)));

  assert_oppop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=>
      (top_ptr == $past(top_ptr) || top_ptr == IDX_W'($past(top_ptr) + 1'b1)));

  assert_unf_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_flag) |->
      $past(rd_en || (cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd5))));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(cmd_valid && cmd_op == 3'd1)) |=> ovf_flag);

  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag && !(cmd_valid && cmd_op == 3'd1)) |=> unf_flag);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(top_ptr) && $stable(tags_q) && !st_valid));

endmodule

bind stk_regfile stk_regfile_chk #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/stk_regfile_tb.sv
module stk_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [63:0] cmd_data;
  logic        rd_en;
  logic [2:0]  rd_idx;
  logic [63:0] rd_data;
  logic        rd_valid;
  logic        st_valid;
  logic [63:0] st_data;
  logic [2:0]  top_ptr;
  logic        ovf_flag;
  logic        unf_flag;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // Reference model state
  logic [63:0] m_data [8];
  bit          m_tag  [8];
  int          m_ptr;
  bit          m_ovf, m_unf, m_stv;
  logic [63:0] m_std;

  always #10 clk = ~clk;

  stk_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .st_valid(st_valid),
    .st_data(st_data), .top_ptr(top_ptr), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  function automatic int phys(int p, int i);
    return (p + i) & 7;
  endfunction

  function automatic string ptr_req(bit v, int op);
    if (!v) return "R9";
    case (op)
      1: return "R1";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_tag[i] = 0;
    m_ptr = 0; m_ovf = 0; m_unf = 0; m_stv = 0;
  endtask

  // Called right after an edge (+1): compare ports, sweep the read port.
  task automatic check_all(input string preq);
    chk(preq, 64'(top_ptr), 64'(m_ptr));
    chk("R3/R8 ovf", 64'(ovf_flag), 64'(m_ovf));
    chk("R7/R8 unf", 64'(unf_flag), 64'(m_unf));
    chk("R4 st_valid", 64'(st_valid), 64'(m_stv));
    if (m_stv) chk("R4/R5 st_data", st_data, m_std);
    rd_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1;
      chk("R2 rd_valid", 64'(rd_valid), 64'(m_tag[phys(m_ptr, i)]));
      if (m_tag[phys(m_ptr, i)]) chk("R2 rd_data", rd_data, m_data[phys(m_ptr, i)]);
    end
  endtask

  // Entered just after a falling edge.
  task automatic apply(input bit v, input int op, input int idx,
                       input logic [63:0] d, input bit re, input int ridx);
    int pa, t;
    cmd_valid = v; cmd_op = 3'(op); cmd_idx = 3'(idx); cmd_data = d;
    rd_en = re; rd_idx = 3'(ridx);
    m_stv = 0;
    if (re && !(v && op == 1) && !m_tag[phys(m_ptr, ridx)]) m_unf = 1;
    if (v) begin
      case (op)
        1: model_reset();
        2: begin
          pa = (m_ptr + 7) & 7;
          if (m_tag[pa]) m_ovf = 1;
          else begin m_data[pa] = d; m_tag[pa] = 1; m_ptr = pa; end
        end
        3, 4: begin
          if (m_tag[m_ptr]) begin
            m_stv = 1; m_std = m_data[m_ptr];
            if (op == 4) begin m_tag[m_ptr] = 0; m_ptr = (m_ptr + 1) & 7; end
          end else m_unf = 1;
        end
        5: begin
          t = phys(m_ptr, idx);
          if (m_tag[m_ptr] && m_tag[t]) begin
            m_data[t] = d; m_tag[m_ptr] = 0; m_ptr = (m_ptr + 1) & 7;
          end else m_unf = 1;
        end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_op = 3'd0; rd_en = 1'b0;
    check_all(ptr_req(v, op));
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    int r;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_idx = 3'd0;
    cmd_data = '0; rd_en = 1'b0; rd_idx = 3'd0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_all("R1 reset");
    @(negedge clk);

    // Directed: fill all eight (R3), then overflow (R3) and stickiness (R8)
    for (int i = 0; i < 8; i++) apply(1, 2, 0, 64'hA000_0000_0000_0000 + 64'(i), 0, 0);
    apply(1, 2, 0, 64'hDEAD, 0, 0);
    apply(1, 0, 0, 0, 0, 0);
    apply(0, 2, 0, 64'hBEEF, 0, 0);          // R9 strobe low
    apply(1, 7, 0, 64'hBEEF, 0, 0);          // R9 unused code
    apply(1, 3, 0, 0, 0, 0);                 // R4 store
    apply(1, 4, 0, 0, 0, 0);                 // R5 store-pop
    apply(1, 5, 2, 64'h1111_2222, 0, 0);     // R6 target idx 2
    apply(1, 5, 0, 64'h3333, 0, 0);          // R6 idx 0 discarded
    apply(1, 1, 0, 0, 0, 0);                 // R1 init
    apply(1, 4, 0, 0, 0, 0);                 // R7 store-pop empty
    apply(1, 1, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 1, 5);                 // R7 read of empty
    apply(1, 1, 0, 0, 0, 0);
    apply(1, 2, 0, 64'h55, 0, 0);
    apply(1, 5, 3, 64'h66, 0, 0);            // R7 empty target
    apply(1, 1, 0, 0, 0, 0);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      r = $urandom_range(0, 99);
      if      (r < 2)  apply(1, 1, 0, 0, $urandom_range(0, 9) == 0, $urandom_range(0, 7));
      else if (r < 42) apply(1, 2, 0, {$urandom, $urandom}, $urandom_range(0, 9) == 0, $urandom_range(0, 7));
      else if (r < 52) apply(1, 3, 0, 0, 0, 0);
      else if (r < 66) apply(1, 4, 0, 0, 0, 0);
      else if (r < 86) apply(1, 5, $urandom_range(0, 7), {$urandom, $urandom}, 0, 0);
      else if (r < 91) apply(1, $urandom_range(6, 7), 0, {$urandom, $urandom}, 0, 0);
      else             apply(0, $urandom_range(0, 7), 0, 0, $urandom_range(0, 3) == 0, $urandom_range(0, 7));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule